// File: doc/BRIEF.md
# Dual/Quad Output Read Data Path

This block is the read engine of a serial flash slave for the two wide-output read modes. A read opens when chip select goes low. The host then sends an 8-bit command, a 24-bit address and 8 don't-care bits, all on line 0 and sampled on rising clock edges. After the last don't-care bit, the block turns the data lines around. It then streams memory bytes out on two lines (dual mode) or four lines (quad mode), with new bits on every falling clock edge.

The block runs on a fast system clock. The serial clock reaches it as one-cycle `sck_rise` and `sck_fall` strobes produced by a front end. Memory bytes come through a simple fetch port: the block raises `fetch_req` with an address, and the byte must be on `fetch_data` one system clock later. The byte must stay there until the next request. For each of the four lines, the block gives an output value and an output enable. The pad logic combines these with the pin's input role.

Top module: `flash_wide_read`

## Requirements
- R1: Command byte 0x3B selects dual output and 0x6B selects quad output. Any other command byte leaves every output enable low and issues no fetch until chip select has been high and then low again.
- R2: The header is 40 bits on `io0_in`, sampled at `sck_rise`, most significant bit first: command, then 24 address bits, then 8 ignored bits. Address bits 23..20 are discarded, so the first byte fetched is at address bits 19..0.
- R3: No output enable is high during the header. Enables rise at the first `sck_fall` after the 40th rising strobe, never earlier.
- R4: In dual mode, lines 1 and 0 are enabled and lines 3 and 2 stay disabled. Each falling strobe puts two bits out, with line 1 carrying the more significant bit, so a byte takes four falling strobes.
- R5: In quad mode, all four lines are enabled. Each falling strobe puts four bits out, with line 3 most significant, so a byte takes two falling strobes.
- R6: Bytes leave most significant bit first. Successive bytes come from successive addresses, each requested by a one-cycle `fetch_req` carrying its address on `fetch_addr`.
- R7: The address counter is 20 bits wide. After address 0xFFFFF the next byte is read from 0x00000.
- R8: Raising chip select drops all four output enables in the same cycle. The next low period starts a fresh header.
- R9: After reset, all output enables and `fetch_req` are low.
- R10: The `io_out` lines change only in the system cycle that follows a falling strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck_rise | input | 1 | One-cycle strobe for a serial clock rising edge |
| sck_fall | input | 1 | One-cycle strobe for a serial clock falling edge |
| io0_in | input | 1 | Received value of line 0 (serial input pin) |
| io_out | output | 4 | Values driven onto lines 3..0 |
| io_oe | output | 4 | Per-line output enables for lines 3..0 |
| fetch_req | output | 1 | Byte fetch request, one cycle |
| fetch_addr | output | 20 | Address of the requested byte |
| fetch_data | input | 8 | Fetched byte, valid one cycle after the request |

## Verification
The assertions rely on several properties of the inputs. The two strobes are never high in the same cycle. Consecutive falling strobes are at least four system cycles apart, which leaves time for a fetch to land. Chip select changes only while no strobe is active. The bench meets these conditions by issuing every strobe from a single task that drives it for exactly one cycle and then idles three cycles. Chip select is moved only on idle cycles. The memory model answers each request one cycle later and holds the byte until the next request.

// File: rtl/flr_pkg.sv
// Shared types for the wide-output read path.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package flr_pkg;

    // Phase of the current chip-select session.
    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,   // collecting command, address and dummy bits
        PH_DROP = 2'd1,   // command not handled, ignore until deselect
        PH_DATA = 2'd2    // streaming data out on wide lines
    } phase_e;

endpackage

// File: rtl/flr_hdr_rx.sv
// Header receiver: shifts command, address and dummy bits from line 0 on
// rising strobes and decides between dual, quad and ignore.
// Assumes: strobes are one system cycle wide; cs_n high clears the session.
module flr_hdr_rx
    import flr_pkg::*;
#(
    parameter int          ADDR_W   = 20,
    parameter int          OPC_W    = 8,
    parameter int          HADDR_W  = 24,
    parameter int          DUMMY_W  = 8,
    parameter logic [7:0]  OPC_DUAL = 8'h3B,
    parameter logic [7:0]  OPC_QUAD = 8'h6B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_rise,
    input  logic              si,
    output phase_e            phase,
    output logic              quad,
    output logic [ADDR_W-1:0] start_addr,
    output logic              start
);
    localparam int HDR_BITS = OPC_W + HADDR_W + DUMMY_W;
    localparam int CNT_W    = $clog2(HDR_BITS + 1);
    localparam int SR_W     = ADDR_W + DUMMY_W - 1;

    logic [CNT_W-1:0] cnt;
    logic [SR_W-1:0]  sr;
    logic [SR_W:0]    full;

    assign full = {sr, si};

    // Shift header bits, classify the command, and hand over at the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            phase      <= PH_HDR;
            cnt        <= '0;
            sr         <= '0;
            start      <= 1'b0;
            quad       <= quad & rst_n;
            start_addr <= rst_n ? start_addr : '0;
        end else begin
            start <= 1'b0;
            if (sck_rise && phase == PH_HDR) begin
                sr  <= full[SR_W-1:0];
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(OPC_W - 1)) begin
                    if (full[OPC_W-1:0] == OPC_DUAL)      quad  <= 1'b0;
                    else if (full[OPC_W-1:0] == OPC_QUAD) quad  <= 1'b1;
                    else                                  phase <= PH_DROP;
                end
                if (cnt == CNT_W'(HDR_BITS - 1)) begin
                    phase      <= PH_DATA;
                    start_addr <= full[DUMMY_W +: ADDR_W];
                    start      <= 1'b1;
                end
            end
        end
    end

    // R1: a rejected session never reaches the data phase.
    assert_drop_sticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DROP) |=> (phase != PH_DATA));

    // R2: the data phase is entered only on a rising strobe.
    assert_hdr_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase == PH_DATA) |-> $past(sck_rise));

endmodule

// File: rtl/flr_fetch.sv
// Byte fetcher: issues one request at the start address, then one per
// consumed byte at the next address, and holds the returned byte.
// Assumes: fetch_data is valid the cycle after fetch_req and held after.
module flr_fetch #(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              advance,
    input  logic [BYTE_W-1:0] fetch_data,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [BYTE_W-1:0] nxt_byte
);
    logic req_d;

    // Request the first byte, then the following one each time a byte is used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_req  <= 1'b0;
            fetch_addr <= '0;
            req_d      <= 1'b0;
            nxt_byte   <= '0;
        end else begin
            req_d     <= fetch_req;
            fetch_req <= 1'b0;
            if (req_d) nxt_byte <= fetch_data;
            if (!cs_n && start) begin
                fetch_req  <= 1'b1;
                fetch_addr <= start_addr;
            end else if (!cs_n && advance) begin
                fetch_req  <= 1'b1;
                fetch_addr <= fetch_addr + 1'b1;
            end
        end
    end

    // R6: consuming a byte requests the following address.
    assert_next_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !cs_n && !start) |=> (fetch_req && fetch_addr == $past(fetch_addr) + 1'b1));

    // R6: each request lasts a single cycle.
    assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);

endmodule

// File: rtl/flr_lane_drv.sv
// Lane driver: on each falling strobe of the data phase, places the next
// two or four bits of the current byte on the lines and owns the enables.
// Assumes: a fetched byte is in byte_in before each byte's first fall.
module flr_lane_drv #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             active,
    input  logic             quad,
    input  logic             sck_fall,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [LANES-1:0] io_out,
    output logic [LANES-1:0] io_oe,
    output logic             advance
);
    localparam int SLC_W     = $clog2(BYTE_W / 2);
    localparam int DUAL_LAST = BYTE_W / 2 - 1;
    localparam int QUAD_LAST = BYTE_W / 4 - 1;

    logic [BYTE_W-1:0] sh, src, sh_next;
    logic [LANES-1:0]  out_next;
    logic [SLC_W-1:0]  slc, last;
    logic              en;

    // Pick the byte source and the slice that goes out next.
    always_comb begin
        src      = (slc == '0) ? byte_in : sh;
        last     = quad ? SLC_W'(QUAD_LAST) : SLC_W'(DUAL_LAST);
        out_next = quad ? src[BYTE_W-1 -: 4] : {2'b00, src[BYTE_W-1 -: 2]};
        sh_next  = quad ? {src[BYTE_W-5:0], 4'b0000} : {src[BYTE_W-3:0], 2'b00};
    end

    // Advance one slice per falling strobe while the data phase is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            slc     <= '0;
            io_out  <= '0;
            en      <= 1'b0;
            advance <= 1'b0;
        end else begin
            advance <= 1'b0;
            if (cs_n) begin
                en  <= 1'b0;
                slc <= '0;
            end else if (active && sck_fall) begin
                en      <= 1'b1;
                io_out  <= out_next;
                sh      <= sh_next;
                advance <= (slc == '0);
                slc     <= (slc == last) ? '0 : slc + 1'b1;
            end
        end
    end

    // Per-line enables: lines 0 and 1 in both modes, upper lines in quad only.
    for (genvar i = 0; i < LANES; i++) begin : g_oe
        if (i < 2) begin : g_low
            assign io_oe[i] = en & ~cs_n;
        end else begin : g_high
            assign io_oe[i] = en & ~cs_n & quad;
        end
    end

    // R10: driven values change only after a falling strobe.
    assert_out_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(io_out));

    // R3: drivers turn on only at a falling strobe inside the data phase.
    assert_oe_at_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> ($past(sck_fall) && $past(active)));

    // R8: a deselect clears the driver state on the next cycle.
    assert_deselect_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !en);

endmodule

// File: rtl/flash_wide_read.sv
// Top of the dual/quad output read path: header receiver, byte fetcher
// and lane driver.
// Assumes: front end supplies one-cycle serial clock strobes at least
// four system cycles apart per falling edge.
module flash_wide_read
    import flr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              io0_in,
    output logic [LANES-1:0]  io_out,
    output logic [LANES-1:0]  io_oe,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic [BYTE_W-1:0] fetch_data
);
    phase_e            phase;
    logic              quad, start, advance;
    logic [ADDR_W-1:0] start_addr;
    logic [BYTE_W-1:0] nxt_byte;

    flr_hdr_rx #(.ADDR_W(ADDR_W)) i_hdr (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise), .si(io0_in),
        .phase(phase), .quad(quad), .start_addr(start_addr), .start(start)
    );

    flr_fetch #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_fetch (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start(start),
        .start_addr(start_addr), .advance(advance), .fetch_data(fetch_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .nxt_byte(nxt_byte)
    );

    flr_lane_drv #(.LANES(LANES), .BYTE_W(BYTE_W)) i_drv (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .active(phase == PH_DATA),
        .quad(quad), .sck_fall(sck_fall), .byte_in(nxt_byte),
        .io_out(io_out), .io_oe(io_oe), .advance(advance)
    );

    // R3: no line is driven outside the data phase.
    assert_oe_only_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe != '0) |-> (phase == PH_DATA));

    // R1: a rejected command never produces a fetch.
    assert_no_fetch_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DROP) |=> !fetch_req);

endmodule

// File: tb/test_flash_wide_read.sv
// Directed bench for the wide-output read path.
module test_flash_wide_read;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck_rise = 1'b0;
    logic        sck_fall = 1'b0;
    logic        io0_in = 1'b0;
    logic [3:0]  io_out, io_oe;
    logic        fetch_req;
    logic [19:0] fetch_addr;
    logic [7:0]  fetch_data;

    int nchk = 0, nfail = 0, nreq = 0;
    logic [19:0] last_req = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_wide_read i_flash_wide_read (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .io0_in(io0_in), .io_out(io_out), .io_oe(io_oe), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data)
    );

    function automatic logic [7:0] pat(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
    endfunction

    // Memory model: answers one cycle after each request and holds the byte.
    always @(posedge clk) begin
        if (!rst_n) fetch_data <= 8'h00;
        else if (fetch_req) begin
            fetch_data <= pat(fetch_addr);
            nreq       <= nreq + 1;
            last_req   <= fetch_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rise_bit(input logic b);
        @(negedge clk); io0_in = b; sck_rise = 1'b1;
        @(negedge clk); sck_rise = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic fall_only();
        @(negedge clk); sck_fall = 1'b1;
        @(negedge clk); sck_fall = 1'b0;
    endtask

    // Select, then send command, 24-bit address and 8 dummy bits.
    task automatic send_header(input logic [7:0] opc, input logic [23:0] a);
        logic [39:0] h;
        h = {opc, a, 8'h00};
        @(negedge clk); cs_n = 1'b0;
        for (int i = 39; i >= 0; i--) begin
            rise_bit(h[i]);
            if (i > 0) begin
                fall_only();
                repeat (3) @(negedge clk);
            end
        end
    endtask

    task automatic deselect();
        @(negedge clk); cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Collect one byte; check enables and that lines hold between falls.
    task automatic read_byte(input bit q, input string req, output logic [7:0] b);
        int n;
        logic [3:0] s;
        n = q ? 2 : 4;
        b = '0;
        for (int k = 0; k < n; k++) begin
            fall_only();
            s = io_out;
            chk(io_oe == (q ? 4'b1111 : 4'b0011), q ? "R5" : "R4", "lane enables",
                {28'd0, io_oe}, {28'd0, q ? 4'b1111 : 4'b0011});
            b = q ? {b[3:0], s} : {b[5:0], s[1:0]};
            repeat (3) @(negedge clk);
            if (k == 0) chk(io_out == s, "R10", "lines held between falls", {28'd0, io_out}, {28'd0, s});
            rise_bit(1'b1);
        end
    endtask

    task automatic t_reset();
        chk(io_oe == 4'b0000, "R9", "enables after reset", {28'd0, io_oe}, 0);
        chk(fetch_req == 1'b0, "R9", "fetch_req after reset", {31'd0, fetch_req}, 0);
    endtask

    // Dual read, upper address nibble set (must be dropped).
    task automatic t_dual();
        logic [7:0] b;
        send_header(8'h3B, 24'hF12345);
        chk(io_oe == 4'b0000, "R3", "no enables before first fall", {28'd0, io_oe}, 0);
        chk(last_req == 20'h12345, "R2", "first fetch address", {12'd0, last_req}, 32'h12345);
        for (int k = 0; k < 3; k++) begin
            read_byte(1'b0, "R4", b);
            chk(b == pat(20'h12345 + 20'(k)), "R6", "dual byte", {24'd0, b},
                {24'd0, pat(20'h12345 + 20'(k))});
        end
        deselect();
    endtask

    // Quad read across the top of the array.
    task automatic t_quad_wrap();
        logic [7:0] b;
        logic [19:0] a;
        send_header(8'h6B, 24'h0FFFFE);
        for (int k = 0; k < 4; k++) begin
            a = 20'hFFFFE + 20'(k);
            read_byte(1'b1, "R5", b);
            chk(b == pat(a), (k >= 2) ? "R7" : "R5", "quad byte", {24'd0, b}, {24'd0, pat(a)});
        end
        chk(last_req == 20'h00002, "R7", "prefetch after wrap", {12'd0, last_req}, 32'h2);
        deselect();
    endtask

    // Unsupported command: nothing driven, nothing fetched.
    task automatic t_bad_opcode();
        int r0;
        r0 = nreq;
        send_header(8'h0B, 24'h000100);
        for (int k = 0; k < 4; k++) begin
            fall_only();
            chk(io_oe == 4'b0000, "R1", "enables after bad command", {28'd0, io_oe}, 0);
            repeat (3) @(negedge clk);
            rise_bit(1'b0);
        end
        chk(nreq == r0, "R1", "fetches after bad command", nreq, r0);
        deselect();
    endtask

    // Deselect mid-byte, then a fresh session must start cleanly.
    task automatic t_abort();
        logic [7:0] b;
        send_header(8'h6B, 24'h0ABCD0);
        fall_only();
        chk(io_oe == 4'b1111, "R5", "quad enables on", {28'd0, io_oe}, 32'hF);
        @(negedge clk); cs_n = 1'b1;
        #1;
        chk(io_oe == 4'b0000, "R8", "enables drop with cs_n", {28'd0, io_oe}, 0);
        repeat (3) @(negedge clk);
        send_header(8'h3B, 24'h000777);
        read_byte(1'b0, "R8", b);
        chk(b == pat(20'h00777), "R8", "byte after restart", {24'd0, b}, {24'd0, pat(20'h00777)});
        deselect();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dual();
        t_quad_wrap();
        t_bad_opcode();
        t_abort();
        finish_run();
    end
endmodule